// File: doc/BRIEF.md
# Three-Channel Polyphase Eight-Times Interpolator

This block raises the sample rate of three reference-current channels by a factor of eight. The three channels arrive together as one slow-rate sample set. Each accepted set produces eight output sets, one for each output phase. The block works as a single FIR filter whose coefficients change with the output phase index. It holds this filter as eight sub-filters of four taps each, and all eight share one four-deep history per channel. Between input sets the history does not move. Only the coefficient subset rotates from one output to the next.

The prototype kernel is a 32-tap triangle held in an internal constant ROM. Tap j has weight 16 - |j - 16|. Within every phase the four weights add up to 32, so each sub-filter has a DC gain of one after a right shift by 5. A single multiplier forms all 12 products of one output set in sequence, one per clock cycle. The products are summed per channel, then rounded and clamped to the input width.

Both data edges use valid/ready handshakes. The input port accepts a new set only when the block is idle, which means all eight outputs of the previous set have been taken. The output port holds its data while it waits for the consumer. A consumer that lowers `out_ready` stalls the whole block. In a 12.8 kS/s to 102.4 kS/s system the block finishes each output set long before the next fast-rate slot.

Top module: `interp_x8`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_data` is 0, and every history entry holds zero, so the first set after reset is filtered against zeros.
- R2: A set is accepted on a rising edge with `in_valid` and `in_ready` both high. `in_ready` stays low from that edge until the eighth output handshake. While `in_ready` is low, `in_valid` and `in_data` have no effect on any output.
- R3: Each accepted set yields exactly eight outputs. Their `out_phase` values run 0, 1, ..., 7 in order, and the first one has phase 0.
- R4: Let x0 be the newest accepted sample of a channel, and x1, x2, x3 the three older ones. The output at phase p is then the sum p*x0 + (8+p)*x1 + (16-p)*x2 + (8-p)*x3, divided by 32.
- R5: The division by 32 adds 16 and then shifts right arithmetically, so exact halves round toward plus infinity. The result is clamped to the 16-bit signed range, and full-scale inputs of either sign give full-scale outputs with no wrap.
- R6: The three channels use the same weights, and each channel uses only its own history. Channel c occupies bits [16c+15:16c] of both `in_data` and `out_data`.
- R7: `out_valid` rises exactly 12 clock cycles after the edge that accepted the input set. It also rises exactly 12 cycles after the edge of each earlier output handshake within the same set.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_phase` hold their values.
- R9: After the handshake of the phase-7 output, `in_ready` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample set is valid |
| in_ready | output | 1 | Block is idle and accepts a set |
| in_data | input | 48 | Three signed 16-bit samples, channel 0 in the low bits |
| out_valid | output | 1 | Output sample set is valid |
| out_ready | input | 1 | Consumer accepts the output set |
| out_data | output | 48 | Three signed 16-bit interpolated samples, channel 0 in the low bits |
| out_phase | output | 3 | Output phase index 0..7 of the presented set |

## Verification
Every output set is due 12 clock edges after the edge that accepted the input, or 12 edges after the previous output handshake. The bench samples on falling edges. It counts the falling edges from the one that follows the triggering edge until `out_valid` is seen, and it expects exactly 12. Data and phase are compared with the reference model on the falling edge where `out_valid` is first seen. Those values are compared again after a random stall. `in_ready` is checked on the falling edge after each handshake: it must be low after phases 0 to 6 and high after phase 7.

// File: rtl/interp_pkg.sv
package interp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_SHOW = 2'd2
  } seq_state_t;

  // Triangle kernel: weight of prototype tap j for a peak at index half.
  function automatic int unsigned kern_coef(input int unsigned j, input int unsigned half);
    if (j <= half) return j;
    else           return 2 * half - j;
  endfunction

endpackage

// File: rtl/interp_seq.sv
module interp_seq
  import interp_pkg::*;
#(
  parameter int unsigned L     = 8,
  parameter int unsigned NTERM = 12,
  localparam int unsigned PW   = (L > 1) ? $clog2(L) : 1,
  localparam int unsigned SW   = (NTERM > 1) ? $clog2(NTERM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] phase,
  output logic [SW-1:0] step,
  output logic          calc,
  output logic          shift_en
);

  localparam logic [PW-1:0] LAST_PH   = PW'(L - 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(NTERM - 1);

  seq_state_t state;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_SHOW);
  assign calc      = (state == ST_CALC);
  assign shift_en  = in_valid && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= '0;
      step  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            state <= ST_CALC;
            phase <= '0;
            step  <= '0;
          end
        end
        ST_CALC: begin
          if (step == LAST_STEP) begin
            state <= ST_SHOW;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_SHOW: begin
          if (out_ready) begin
            if (phase == LAST_PH) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_CALC;
              phase <= phase + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R3
  phase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> phase == '0 && !in_ready && !out_valid);

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && phase != LAST_PH |=> !in_ready && phase == PW'($past(phase) + 1'b1));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && phase == LAST_PH |=> in_ready);

endmodule

// File: rtl/interp_delay.sv
module interp_delay #(
  parameter int unsigned NCH = 3,
  parameter int unsigned TPP = 4,
  parameter int unsigned DW  = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               shift_en,
  input  logic [NCH-1:0][DW-1:0]             din,
  output logic [NCH-1:0][TPP-1:0][DW-1:0]    hist
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (shift_en) begin
      for (int c = 0; c < NCH; c++) begin
        hist[c][0] <= din[c];
        for (int t = 1; t < TPP; t++) begin
          hist[c][t] <= hist[c][t-1];
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> hist[c][0] == $past(din[c]));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(hist[c]));
    if (TPP > 1) begin : g_shift
      // R4
      shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[c][1] == $past(hist[c][0]));
    end
  end

endmodule

// File: rtl/interp_mac.sv
module interp_mac
  import interp_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned TPP = 4,
  parameter int unsigned L   = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned NTERM = NCH * TPP,
  localparam int unsigned PW    = (L > 1) ? $clog2(L) : 1,
  localparam int unsigned SW    = (NTERM > 1) ? $clog2(NTERM) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            calc,
  input  logic [SW-1:0]                   step,
  input  logic [PW-1:0]                   phase,
  input  logic [NCH-1:0][TPP-1:0][DW-1:0] hist,
  output logic [NCH-1:0][DW-1:0]          out_data
);

  localparam int unsigned NTAPS = L * TPP;
  localparam int unsigned HALF  = NTAPS / 2;
  localparam int unsigned CFRAC = $clog2(HALF * HALF / L);
  localparam int unsigned CW    = $clog2(HALF + 1);
  localparam int unsigned TW    = (TPP > 1) ? $clog2(TPP) : 1;
  localparam int unsigned CHW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned RW    = (NTAPS > 1) ? $clog2(NTAPS) : 1;
  localparam int unsigned PRW   = DW + CW + 1;
  localparam int unsigned AW    = PRW + TW;

  localparam logic signed [AW-1:0] RND  = AW'(1) << (CFRAC - 1);
  localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // Constant coefficient ROM, built from the kernel function.
  logic [CW-1:0] rom [NTAPS];
  for (genvar j = 0; j < NTAPS; j++) begin : g_rom
    assign rom[j] = CW'(kern_coef(j, HALF));
  end

  logic [CHW-1:0]         ch_idx;
  logic [TW-1:0]          tap_idx;
  logic [RW-1:0]          rom_idx;
  logic signed [DW-1:0]   xs;
  logic signed [CW:0]     cs;
  logic signed [PRW-1:0]  prod;
  logic signed [AW-1:0]   acc [NCH];

  assign ch_idx  = CHW'(int'(step) / TPP);
  assign tap_idx = TW'(int'(step) % TPP);
  assign rom_idx = RW'(int'(tap_idx) * L + int'(phase));
  assign xs      = $signed(hist[ch_idx][tap_idx]);
  assign cs      = $signed({1'b0, rom[rom_idx]});
  assign prod    = PRW'(xs) * PRW'(cs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) acc[c] <= '0;
    end else if (calc) begin
      if (tap_idx == '0) acc[ch_idx] <= AW'(prod);
      else               acc[ch_idx] <= acc[ch_idx] + AW'(prod);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    logic signed [AW-1:0] rnd;
    assign rnd = (acc[c] + RND) >>> CFRAC;
    assign out_data[c] = (rnd > MAXV) ? MAXV[DW-1:0] :
                         (rnd < MINV) ? MINV[DW-1:0] : rnd[DW-1:0];
  end

  // R8
  idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !calc |=> $stable(out_data));

endmodule

// File: rtl/interp_x8.sv
module interp_x8 #(
  parameter int unsigned DW  = 16,
  parameter int unsigned NCH = 3,
  parameter int unsigned L   = 8,
  parameter int unsigned TPP = 4,
  localparam int unsigned PW    = (L > 1) ? $clog2(L) : 1,
  localparam int unsigned NTERM = NCH * TPP,
  localparam int unsigned SW    = (NTERM > 1) ? $clog2(NTERM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*DW-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*DW-1:0] out_data,
  output logic [PW-1:0]     out_phase
);

  logic                            shift_en;
  logic                            calc;
  logic [SW-1:0]                   step;
  logic [PW-1:0]                   phase;
  logic [NCH-1:0][DW-1:0]          din;
  logic [NCH-1:0][TPP-1:0][DW-1:0] hist;
  logic [NCH-1:0][DW-1:0]          res;

  assign din       = in_data;
  assign out_data  = res;
  assign out_phase = phase;

  interp_seq #(.L(L), .NTERM(NTERM)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .phase    (phase),
    .step     (step),
    .calc     (calc),
    .shift_en (shift_en)
  );

  interp_delay #(.NCH(NCH), .TPP(TPP), .DW(DW)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .din     (din),
    .hist    (hist)
  );

  interp_mac #(.NCH(NCH), .TPP(TPP), .L(L), .DW(DW)) u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .calc    (calc),
    .step    (step),
    .phase   (phase),
    .hist    (hist),
    .out_data(res)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_phase));

endmodule

// File: tb/tb_interp_x8.sv
module tb_interp_x8;

  localparam int DW = 16;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [NCH*DW-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [NCH*DW-1:0] out_data;
  logic [2:0]        out_phase;

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;
  int hist [NCH][4];

  always #2.5 clk = ~clk;

  interp_x8 dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_phase(out_phase)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  function automatic longint expect_val(input int c, input int p);
    longint acc;
    acc = longint'(p) * hist[c][0] + longint'(8 + p) * hist[c][1]
        + longint'(16 - p) * hist[c][2] + longint'(8 - p) * hist[c][3];
    acc = (acc + 16) >>> 5;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  function automatic longint chan(input logic [NCH*DW-1:0] v, input int c);
    return longint'($signed(v[c*DW +: DW]));
  endfunction

  task automatic send_set(input int x0, input int x1, input int x2,
                          input int stall_max, input bit junk, input string req);
    int xs [NCH];
    xs[0] = x0; xs[1] = x1; xs[2] = x2;
    chk(in_ready == 1'b1, "R9", "in_ready before send", in_ready, 1);
    in_valid = 1'b1;
    in_data  = {16'(x2), 16'(x1), 16'(x0)};
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      for (int t = 3; t > 0; t--) hist[c][t] = hist[c][t-1];
      hist[c][0] = xs[c];
    end
    if (junk) begin
      in_valid = 1'b1;
      in_data  = {$urandom, $urandom};
    end else begin
      in_valid = 1'b0;
    end
    for (int p = 0; p < 8; p++) begin
      int cnt;
      int stall;
      logic [NCH*DW-1:0] snap;
      cnt = 0;
      while (!out_valid && cnt < 100) begin
        @(negedge clk);
        cnt++;
      end
      chk(cnt == 12, "R7", "latency", cnt, 12);
      chk(out_phase == 3'(p), "R3", "phase", out_phase, p);
      for (int c = 0; c < NCH; c++)
        chk(chan(out_data, c) == expect_val(c, p), req, $sformatf("ch%0d ph%0d", c, p),
            chan(out_data, c), expect_val(c, p));
      stall = (stall_max > 0) ? int'($urandom_range(stall_max, 0)) : 0;
      snap = out_data;
      repeat (stall) @(negedge clk);
      if (stall > 0) begin
        chk(out_valid && out_data == snap && out_phase == 3'(p), "R8", "stall hold",
            chan(out_data, 0), chan(snap, 0));
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      if (p < 7) chk(in_ready == 1'b0, "R2", "busy in_ready", in_ready, 0);
      else       chk(in_ready == 1'b1, "R9", "release in_ready", in_ready, 1);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int c = 0; c < NCH; c++) for (int t = 0; t < 4; t++) hist[c][t] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(out_data == '0, "R1", "out_data", chan(out_data, 0), 0);
    // R1 / R4: impulse against zero history, shows the kernel weights
    send_set(1000, -1000, 0, 0, 0, "R1");
    send_set(0, 0, 0, 0, 0, "R4");
    send_set(0, 0, 0, 2, 0, "R4");
    send_set(0, 0, 0, 0, 0, "R4");
    // R5: exact halves round upward
    send_set(2, -2, 3, 0, 0, "R5");
    send_set(0, 0, 0, 0, 0, "R5");
    send_set(-1, 1, -3, 0, 0, "R5");
    // R5: full scale of both signs, no wrap
    for (int k = 0; k < 4; k++) send_set(32767, -32768, 32767, 1, 0, "R5");
    for (int k = 0; k < 4; k++) send_set(-32768, 32767, -32768, 1, 0, "R5");
    // R2: busy-time input activity is ignored
    for (int k = 0; k < 4; k++) send_set(k * 500 - 700, 1200 - k * 300, k * 77, 2, 1, "R2");
    // R6: independent random channels, random stalls
    for (int k = 0; k < 30; k++)
      send_set(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
               int'($signed(16'($urandom))), 3, k[0], "R6");
    report();
    $finish;
  end

endmodule